// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block takes frames from a serial link whose bit clock comes from outside the chip. The serial clock and the data line both pass through a synchroniser into the system clock domain. On each detected active edge of the serial clock, one data bit is shifted into a private assembly register. When a whole frame has arrived, it moves to a holding register that the host sees on a parallel output.

Two sticky flags describe the state of the holding register: frame-available and overrun. If a frame completes while the previous one is still marked available, the new frame is discarded and the overrun flag is raised. The receiver then stops taking bits until software has cleared both flags. Two level interrupt outputs follow the flags while the host interrupt enable is high. For continuous streaming, the host clears the available flag before the next frame finishes.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset, the data output is 0, both flags are 0 and both interrupt outputs are 0.
- R2: A frame is DATA_W bits, 8 by default, and arrives least significant bit first: the first sampled bit becomes bit 0 of the data output. Each bit is sampled on a rising edge of the serial clock.
- R3: When a frame completes and the available flag is 0, the frame appears on the data output and the available flag becomes 1.
- R4: When a frame completes while the available flag is 1, the overrun flag becomes 1, the data output keeps the older frame and the available flag stays 1.
- R5: With the interrupt enable at 1, the receive interrupt is high while the available flag is 1 and the overrun flag is 0, and the error interrupt is high while the overrun flag is 1. With the enable at 0, both interrupt outputs are 0.
- R6: After an overrun, frames sent on the line are ignored. They change neither the data nor the flags until both flags have been cleared.
- R7: A clear-available strobe in the same cycle as a frame completion counts as done first, so the new frame is accepted without an overrun. This makes back-to-back reception lossless.
- R8: While the receive enable is 0, the bit position returns to the start of a frame and the flags keep their values. After the enable returns to 1, the next DATA_W bits form a frame.
- R9: Each flag is cleared only by its own host strobe and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | External serial bit clock |
| ser_dat_i | input | 1 | Serial data line |
| rx_en_i | input | 1 | Receive enable; low restarts the bit position |
| irq_en_i | input | 1 | Interrupt enable for both interrupt outputs |
| clr_avail_i | input | 1 | One-cycle strobe that clears the available flag |
| clr_ovr_i | input | 1 | One-cycle strobe that clears the overrun flag |
| rx_data_o | output | DATA_W | Held frame |
| avail_o | output | 1 | Frame-available flag |
| ovr_o | output | 1 | Overrun flag |
| irq_rx_o | output | 1 | Receive interrupt (level) |
| irq_err_o | output | 1 | Error interrupt (level) |

## Verification
The bench aims at the overrun path. A receiver that overwrites the held frame shows the newer value on the data output, and one that keeps running after the overrun changes data or flags while it should be halted. Clearing only the overrun flag must leave the receiver stopped; a design that resumes early accepts that frame. A clear strobe timed exactly on the completion cycle checks the ordering of clear and load: the wrong order shows up as a false overrun. The bench also drops the receive enable partway through a frame. A design that keeps its bit count then returns a rotated value, and one that resets the flags there loses the pending available flag.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;

   typedef enum logic {
      SSRX_LSB_FIRST = 1'b0,
      SSRX_MSB_FIRST = 1'b1
   } ssrx_order_e;

   typedef struct packed {
      logic avail;
      logic ovr;
      logic halt;
   } ssrx_flags_t;

endpackage

// File: rtl/ssrx_edge_sync.sv
module ssrx_edge_sync #(
   parameter int unsigned STAGES = 2,
   parameter bit          RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ser_clk_i,
   input  logic ser_dat_i,
   output logic edge_o,
   output logic dat_o
);
   logic [STAGES-1:0] ck_q;
   logic [STAGES-1:0] dt_q;
   logic              ck_prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ssrx_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_q      <= '0;
         dt_q      <= '0;
         ck_prev_q <= 1'b0;
      end else begin
         ck_q      <= {ck_q[STAGES-2:0], ser_clk_i};
         dt_q      <= {dt_q[STAGES-2:0], ser_dat_i};
         ck_prev_q <= ck_q[STAGES-1];
      end
   end

   generate
      if (RISING) begin : g_rise
         assign edge_o = ck_q[STAGES-1] & ~ck_prev_q;
      end else begin : g_fall
         assign edge_o = ~ck_q[STAGES-1] & ck_prev_q;
      end
   endgenerate

   assign dat_o = dt_q[STAGES-1];

   // R2: an edge pulse lasts one cycle
   a_r2_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o);

endmodule

// File: rtl/ssrx_shifter.sv
module ssrx_shifter
   import ssrx_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter ssrx_order_e ORDER  = SSRX_LSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              edge_i,
   input  logic              bit_i,
   output logic              done_o,
   output logic [DATA_W-1:0] word_o
);
   localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] sr_q;
   logic [DATA_W-1:0] sr_next;
   logic [DATA_W-1:0] word_q;
   logic              done_q;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("ssrx_shifter: DATA_W must be at least 2");
      end
      if (ORDER == SSRX_LSB_FIRST) begin : g_lsb
         assign sr_next = {bit_i, sr_q[DATA_W-1:1]};
      end else begin : g_msb
         assign sr_next = {sr_q[DATA_W-2:0], bit_i};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sr_q   <= '0;
         word_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!run_i) begin
            cnt_q <= '0;
         end else if (edge_i) begin
            sr_q <= sr_next;
            if (cnt_q == LAST_IDX) begin
               cnt_q  <= '0;
               done_q <= 1'b1;
               word_q <= sr_next;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign done_o = done_q;
   assign word_o = word_q;

   // R8: a stopped receiver is back at bit position zero
   a_r8_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));
   // R2: completions are separated by whole frames
   a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R2: bit position never passes the frame length
   a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_IDX);

endmodule

// File: rtl/ssrx_status.sv
module ssrx_status
   import ssrx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic              clr_avail_i,
   input  logic              clr_ovr_i,
   input  logic              irq_en_i,
   output logic [DATA_W-1:0] data_o,
   output ssrx_flags_t       flags_o,
   output logic              irq_rx_o,
   output logic              irq_err_o
);
   logic [DATA_W-1:0] data_q;
   ssrx_flags_t       fl_q;
   ssrx_flags_t       fl_d;
   logic              avail_keep;
   logic              accept;
   logic              overrun;

   always_comb begin
      avail_keep = fl_q.avail & ~clr_avail_i;
      accept     = done_i & ~fl_q.halt & ~avail_keep;
      overrun    = done_i & ~fl_q.halt & avail_keep;
      fl_d.avail = accept | avail_keep;
      fl_d.ovr   = overrun | (fl_q.ovr & ~clr_ovr_i);
      if (overrun)
         fl_d.halt = 1'b1;
      else if (!fl_d.ovr && !fl_d.avail)
         fl_d.halt = 1'b0;
      else
         fl_d.halt = fl_q.halt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         fl_q   <= '0;
      end else begin
         fl_q <= fl_d;
         if (accept)
            data_q <= word_i;
      end
   end

   assign data_o    = data_q;
   assign flags_o   = fl_q;
   assign irq_rx_o  = irq_en_i & fl_q.avail & ~fl_q.ovr;
   assign irq_err_o = irq_en_i & fl_q.ovr;

   // R4: overrun leaves held data alone
   a_r4_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_q.ovr) |-> $stable(data_q));
   // R4: overrun only arises on top of a held frame
   a_r4_ovr_needs_avail: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_q.ovr) |-> $past(fl_q.avail));
   // R9: flags are sticky until their own strobe
   a_r9_avail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_q.avail && !clr_avail_i) |=> fl_q.avail);
   a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_q.ovr && !clr_ovr_i) |=> fl_q.ovr);
   // R6: a halted receiver takes no new frame
   a_r6_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      fl_q.halt |=> $stable(data_q));

endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
   import ssrx_pkg::*;
#(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          LSB_FIRST     = 1'b1,
   parameter bit          SAMPLE_RISING = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_dat_i,
   input  logic              rx_en_i,
   input  logic              irq_en_i,
   input  logic              clr_avail_i,
   input  logic              clr_ovr_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              avail_o,
   output logic              ovr_o,
   output logic              irq_rx_o,
   output logic              irq_err_o
);
   localparam ssrx_order_e ORDER = LSB_FIRST ? SSRX_LSB_FIRST : SSRX_MSB_FIRST;

   generate
      if (DATA_W < 2 || DATA_W > 64) begin : g_bad_width
         $error("sync_serial_rx: DATA_W out of range 2..64");
      end
      if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("sync_serial_rx: SYNC_STAGES out of range 2..4");
      end
   endgenerate

   logic              smp_edge;
   logic              smp_bit;
   logic              frm_done;
   logic [DATA_W-1:0] frm_word;
   ssrx_flags_t       flags;
   logic              run;

   ssrx_edge_sync #(.STAGES(SYNC_STAGES), .RISING(SAMPLE_RISING)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_clk_i (ser_clk_i),
      .ser_dat_i (ser_dat_i),
      .edge_o    (smp_edge),
      .dat_o     (smp_bit)
   );

   assign run = rx_en_i & ~flags.halt;

   ssrx_shifter #(.DATA_W(DATA_W), .ORDER(ORDER)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .edge_i (smp_edge),
      .bit_i  (smp_bit),
      .done_o (frm_done),
      .word_o (frm_word)
   );

   ssrx_status #(.DATA_W(DATA_W)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .done_i      (frm_done),
      .word_i      (frm_word),
      .clr_avail_i (clr_avail_i),
      .clr_ovr_i   (clr_ovr_i),
      .irq_en_i    (irq_en_i),
      .data_o      (rx_data_o),
      .flags_o     (flags),
      .irq_rx_o    (irq_rx_o),
      .irq_err_o   (irq_err_o)
   );

   assign avail_o = flags.avail;
   assign ovr_o   = flags.ovr;

   // R5: the two interrupt outputs are never high together
   a_r5_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_rx_o && irq_err_o));
   // R5: error interrupt implies overrun flag
   a_r5_err_needs_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err_o |-> ovr_o);

endmodule

// File: tb/test_sync_serial_rx.sv
module test_sync_serial_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_dat = 1'b0;
   logic       rx_en = 1'b1;
   logic       irq_en = 1'b1;
   logic       clr_avail = 1'b0;
   logic       clr_ovr = 1'b0;
   logic [7:0] rx_data;
   logic       avail, ovr, irq_rx, irq_err;
   int         n_tests = 0;
   int         n_fail = 0;

   always #2 clk = ~clk;

   sync_serial_rx i_sync_serial_rx (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
      .rx_en_i(rx_en), .irq_en_i(irq_en), .clr_avail_i(clr_avail),
      .clr_ovr_i(clr_ovr), .rx_data_o(rx_data), .avail_o(avail),
      .ovr_o(ovr), .irq_rx_o(irq_rx), .irq_err_o(irq_err)
   );

   localparam int NVEC = 6;
   localparam logic [7:0] VEC [NVEC] = '{8'h01, 8'h80, 8'hA5, 8'h3C, 8'hFF, 8'h00};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bits(input logic [7:0] v, input int nbits, input bit clr_last);
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk);
         ser_dat = v[i];
         ser_clk = 1'b0;
         repeat (4) @(negedge clk);
         ser_clk = 1'b1;
         if (i == 7 && clr_last) begin
            repeat (3) @(negedge clk);
            clr_avail = 1'b1;
            @(negedge clk);
            clr_avail = 1'b0;
         end else begin
            repeat (4) @(negedge clk);
         end
      end
      @(negedge clk);
      ser_clk = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic pulse_avail();
      @(negedge clk); clr_avail = 1'b1; @(negedge clk); clr_avail = 1'b0;
   endtask

   task automatic pulse_ovr();
      @(negedge clk); clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 data", rx_data, 0);
      chk("R1 flags", {avail, ovr}, 0);
      chk("R1 irq", {irq_rx, irq_err}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R3 R5 vector loop
      for (int k = 0; k < NVEC; k++) begin
         send_bits(VEC[k], 8, 1'b0);
         chk("R2 data lsb first", rx_data, VEC[k]);
         chk("R3 avail set", avail, 1);
         chk("R5 irq_rx level", {irq_rx, irq_err}, 2'b10);
         pulse_avail();
         @(negedge clk);
         chk("R9 avail cleared by strobe", avail, 0);
      end

      // R5 interrupt disable
      irq_en = 1'b0;
      send_bits(8'h5A, 8, 1'b0);
      chk("R5 irq masked", {irq_rx, irq_err}, 0);
      irq_en = 1'b1;
      @(negedge clk);
      chk("R5 irq re-enabled", irq_rx, 1);

      // R7 clear strobe on completion cycle
      send_bits(8'hC3, 8, 1'b1);
      chk("R7 same-cycle data", rx_data, 8'hC3);
      chk("R7 no overrun", {avail, ovr}, 2'b10);

      // R4 overrun keeps old frame
      send_bits(8'h11, 8, 1'b0);
      chk("R4 data kept", rx_data, 8'hC3);
      chk("R4 flags", {avail, ovr}, 2'b11);
      chk("R5 error irq", {irq_rx, irq_err}, 2'b01);

      // R6 halted receiver ignores frames
      send_bits(8'h22, 8, 1'b0);
      chk("R6 data while halted", rx_data, 8'hC3);
      pulse_ovr();
      @(negedge clk);
      chk("R9 ovr cleared", {avail, ovr}, 2'b10);
      send_bits(8'h33, 8, 1'b0);
      chk("R6 still halted with avail set", rx_data, 8'hC3);
      chk("R6 no new overrun", {avail, ovr}, 2'b10);
      pulse_avail();
      send_bits(8'h44, 8, 1'b0);
      chk("R6 resumed", rx_data, 8'h44);
      chk("R6 flags after resume", {avail, ovr}, 2'b10);

      // R8 enable drop mid-frame with avail held
      send_bits(8'h00, 3, 1'b0);
      @(negedge clk); rx_en = 1'b0;
      repeat (4) @(negedge clk);
      chk("R8 flags kept while disabled", {avail, ovr}, 2'b10);
      rx_en = 1'b1;
      pulse_avail();
      send_bits(8'h96, 8, 1'b0);
      chk("R8 frame realigned", rx_data, 8'h96);
      chk("R8 avail", avail, 1);

      summary();
   end
endmodule